// File: doc/BRIEF.md
# Serial-Acknowledge Priority Interrupt Arbiter

This block resolves simultaneous interrupt requests from a row of source cells. Each cell keeps a pending flag. The flags are OR-ed onto one shared request line. When the processor-side sequencer sees that line while the global enable is on, it raises an acknowledge for a single clock.

That acknowledge enters the cell nearest the processor and ripples down the row. A cell with nothing pending passes it on. The first pending cell that the acknowledge reaches stops it, so cells further down see it low. That cell places its vector on an internal bus, and its pending flag drops at the end of the acknowledge cycle. Priority therefore comes only from a cell's place in the row.

The sequencer captures the bus value and offers it on a valid/ready output stream. The vector stays on the stream until it is taken. While a captured vector is waiting there, no new acknowledge is issued. This is how back-pressure reaches the row.

Top module: `irq_chain_top`

## Requirements
- R1: `irq_line` is high in the cycle after any cell's pending flag is set by a `src_set` bit. It is low when no flag is pending.
- R2: An acknowledge starts only when `glb_en` and `irq_line` are both high in a cycle where the sequencer is idle. `ack` goes high in the following cycle and lasts exactly one clock.
- R3: The pending cell with the lowest index wins the acknowledge. Index 0 is the highest priority.
- R4: The vector of cell i is `VEC_BASE + i*VEC_STEP`. With the defaults this is 8'h40 + 4*i.
- R5: Only the winning cell's pending flag is cleared at the end of the acknowledge cycle. All other flags keep their state.
- R6: If no cell is pending during the acknowledge cycle, the delivered vector is zero and `vec_spur` is high. Otherwise `vec_spur` is low.
- R7: A `src_set` bit wins over a clear in the same cycle, whether the clear comes from service or from `src_clr`. The cell stays pending.
- R8: `vec_valid` rises in the cycle after `ack`. `vec_data` and `vec_spur` stay stable while `vec_valid` is high and `vec_ready` is low. A transfer happens on a clock where both are high. No `ack` is issued while `vec_valid` is high.
- R9: While `glb_en` is low, no acknowledge is issued and pending flags are kept.
- R10: A `src_clr` bit withdraws a cell's pending request in the next cycle, unless R7 applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| glb_en | input | 1 | Global interrupt enable for the sequencer |
| src_set | input | N | Per-cell request set pulses |
| src_clr | input | N | Per-cell request withdraw pulses |
| irq_line | output | 1 | Shared request line, the OR of all pending flags |
| ack | output | 1 | Acknowledge entering cell 0 |
| vec_valid | output | 1 | Captured vector available |
| vec_ready | input | 1 | Consumer accepts the vector |
| vec_data | output | VEC_W | Captured vector, zero when spurious |
| vec_spur | output | 1 | No cell claimed the acknowledge |

## Verification
The hardest case to reach is a spurious acknowledge. It needs the request line to be seen high on the same edge that withdraws the only pending request. To get there, the bench holds `glb_en` low with one cell pending. On a single falling edge it then raises `glb_en` and pulses that cell's `src_clr`.

Set-beats-clear during service is a similar timing case. The bench watches for `ack`, pulses the winner's `src_set` inside that very cycle, and expects the same vector a second time.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    CS_IDLE = 2'd0,
    CS_ACK  = 2'd1,
    CS_HOLD = 2'd2
  } ctl_state_t;
endpackage

// File: rtl/irq_cell.sv
module irq_cell #(
  parameter int VEC_W = 8,
  parameter logic [VEC_W-1:0] CELL_VEC = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_i,
  input  logic             clr_i,
  input  logic             pi,
  output logic             po,
  output logic             pend_o,
  output logic [VEC_W-1:0] vec_o
);
  logic pend_q;
  logic claim;

  // The acknowledge reaching an idle cell travels on; a pending cell stops it.
  assign po     = pi & ~pend_q;
  assign claim  = pi & pend_q;
  assign vec_o  = claim ? CELL_VEC : '0;
  assign pend_o = pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                pend_q <= 1'b0;
    else if (set_i)            pend_q <= 1'b1;
    else if (clr_i || claim)   pend_q <= 1'b0;
  end
endmodule

// File: rtl/irq_chain.sv
module irq_chain #(
  parameter int N        = 4,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 64,
  parameter int VEC_STEP = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     set_i,
  input  logic [N-1:0]     clr_i,
  input  logic             ack_i,
  output logic             any_pend,
  output logic             claimed,
  output logic [VEC_W-1:0] bus
);
  logic [N:0]       link;
  logic [N-1:0]     pend;
  logic [VEC_W-1:0] drv [N];

  assign link[0] = ack_i;

  for (genvar i = 0; i < N; i++) begin : g_cell
    localparam logic [VEC_W-1:0] CV = VEC_W'(VEC_BASE + i * VEC_STEP);
    irq_cell #(.VEC_W(VEC_W), .CELL_VEC(CV)) u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (set_i[i]),
      .clr_i  (clr_i[i]),
      .pi     (link[i]),
      .po     (link[i+1]),
      .pend_o (pend[i]),
      .vec_o  (drv[i])
    );
  end

  always_comb begin
    bus = '0;
    for (int i = 0; i < N; i++) bus = bus | drv[i];
  end

  assign any_pend = |pend;
  // The acknowledge left the far end untouched only if nobody claimed it.
  assign claimed  = ack_i & ~link[N];
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             glb_en,
  input  logic             line_i,
  input  logic             claimed_i,
  input  logic [VEC_W-1:0] bus_i,
  output logic             ack_o,
  output logic             vec_valid,
  input  logic             vec_ready,
  output logic [VEC_W-1:0] vec_data,
  output logic             vec_spur
);
  ctl_state_t st_q;
  logic [VEC_W-1:0] data_q;
  logic spur_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= CS_IDLE;
      data_q <= '0;
      spur_q <= 1'b0;
    end else begin
      unique case (st_q)
        CS_IDLE: if (glb_en && line_i) st_q <= CS_ACK;
        CS_ACK: begin
          data_q <= claimed_i ? bus_i : '0;
          spur_q <= ~claimed_i;
          st_q   <= CS_HOLD;
        end
        CS_HOLD: if (vec_ready) st_q <= CS_IDLE;
        default: st_q <= CS_IDLE;
      endcase
    end
  end

  assign ack_o     = (st_q == CS_ACK);
  assign vec_valid = (st_q == CS_HOLD);
  assign vec_data  = data_q;
  assign vec_spur  = spur_q;
endmodule

// File: rtl/irq_chain_top.sv
module irq_chain_top #(
  parameter int N        = 4,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 64,
  parameter int VEC_STEP = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             glb_en,
  input  logic [N-1:0]     src_set,
  input  logic [N-1:0]     src_clr,
  output logic             irq_line,
  output logic             ack,
  output logic             vec_valid,
  input  logic             vec_ready,
  output logic [VEC_W-1:0] vec_data,
  output logic             vec_spur
);
  logic             claimed;
  logic [VEC_W-1:0] bus;

  irq_chain #(.N(N), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)) u_chain (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_i    (src_set),
    .clr_i    (src_clr),
    .ack_i    (ack),
    .any_pend (irq_line),
    .claimed  (claimed),
    .bus      (bus)
  );

  irq_ctrl #(.VEC_W(VEC_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .glb_en    (glb_en),
    .line_i    (irq_line),
    .claimed_i (claimed),
    .bus_i     (bus),
    .ack_o     (ack),
    .vec_valid (vec_valid),
    .vec_ready (vec_ready),
    .vec_data  (vec_data),
    .vec_spur  (vec_spur)
  );
endmodule

// File: rtl/irq_chain_chk.sv
module irq_chain_chk #(
  parameter int N     = 4,
  parameter int VEC_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             glb_en,
  input logic [N-1:0]     src_set,
  input logic             irq_line,
  input logic             ack,
  input logic             vec_valid,
  input logic             vec_ready,
  input logic [VEC_W-1:0] vec_data,
  input logic             vec_spur
);
  assert_ack_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);
  assert_ack_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack) |-> $past(glb_en && irq_line));
  assert_ack_no_en_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!glb_en && !ack && !vec_valid) |=> !ack);
  assert_valid_after_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> vec_valid);
  assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && !vec_ready) |=> (vec_valid && $stable(vec_data) && $stable(vec_spur)));
  assert_no_ack_while_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> !ack);
  assert_spur_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && vec_spur) |-> (vec_data == '0));
  assert_real_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && !vec_spur) |-> (vec_data != '0));
  assert_line_on_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_set) |=> irq_line);
endmodule

bind irq_chain_top irq_chain_chk #(.N(N), .VEC_W(VEC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .glb_en    (glb_en),
  .src_set   (src_set),
  .irq_line  (irq_line),
  .ack       (ack),
  .vec_valid (vec_valid),
  .vec_ready (vec_ready),
  .vec_data  (vec_data),
  .vec_spur  (vec_spur)
);

// File: tb/sim_irq_chain_top.sv
`timescale 1ns/1ps
module sim_irq_chain_top;
  localparam int N = 4;
  localparam int VW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic glb_en = 1'b0;
  logic [N-1:0] src_set = '0;
  logic [N-1:0] src_clr = '0;
  logic vec_ready = 1'b0;
  logic irq_line, ack, vec_valid, vec_spur;
  logic [VW-1:0] vec_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  logic [N-1:0] model = '0;

  always #4 clk = ~clk;

  irq_chain_top #(.N(N), .VEC_W(VW), .VEC_BASE(64), .VEC_STEP(4)) u0 (
    .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .src_set(src_set), .src_clr(src_clr),
    .irq_line(irq_line), .ack(ack), .vec_valid(vec_valid), .vec_ready(vec_ready),
    .vec_data(vec_data), .vec_spur(vec_spur)
  );

  function automatic logic [VW-1:0] vec_of(int i);
    return VW'(64 + 4 * i);
  endfunction

  function automatic int lowest(logic [N-1:0] m);
    for (int i = 0; i < N; i++) if (m[i]) return i;
    return -1;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // Wait for a vector, apply random stall, check stability, then take it.
  task automatic take(output logic [VW-1:0] d, output logic s);
    int stall;
    while (!vec_valid) tick();
    d = vec_data;
    s = vec_spur;
    stall = int'($urandom % 4);
    for (int k = 0; k < stall; k++) begin
      tick();
      chk(vec_valid && vec_data == d, "R8", int'(vec_data), int'(d));
    end
    vec_ready = 1'b1;
    tick();
    vec_ready = 1'b0;
  endtask

  task automatic pulse_set(logic [N-1:0] m);
    src_set = m;
    tick();
    src_set = '0;
    model = model | m;
  endtask

  initial begin
    logic [VW-1:0] d;
    logic s;
    int w;
    void'($urandom(32'd2024));
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    chk(irq_line == 0 && ack == 0 && vec_valid == 0, "R1", int'({irq_line, ack, vec_valid}), 0);

    // R9: requests held while disabled
    pulse_set(4'b1010);
    chk(irq_line == 1, "R1", int'(irq_line), 1);
    repeat (10) begin
      tick();
      chk(ack == 0 && vec_valid == 0, "R9", int'({ack, vec_valid}), 0);
    end
    chk(irq_line == 1, "R9", int'(irq_line), 1);
    glb_en = 1'b1;
    tick();
    chk(ack == 1, "R2", int'(ack), 1);
    tick();
    chk(ack == 0 && vec_valid == 1, "R2", int'({ack, vec_valid}), 1);
    take(d, s);
    chk(d == vec_of(1) && !s, "R3", int'(d), int'(vec_of(1)));
    model[1] = 1'b0;
    take(d, s);
    chk(d == vec_of(3) && !s, "R4", int'(d), int'(vec_of(3)));
    model[3] = 1'b0;
    tick();
    chk(irq_line == 0, "R5", int'(irq_line), 0);

    // R7: set during the acknowledge of the same cell keeps it pending
    pulse_set(4'b0100);
    w = 0;
    while (!ack && w < 20) begin tick(); w++; end
    src_set = 4'b0100;
    tick();
    src_set = '0;
    take(d, s);
    chk(d == vec_of(2), "R7", int'(d), int'(vec_of(2)));
    take(d, s);
    chk(d == vec_of(2) && !s, "R7", int'(d), int'(vec_of(2)));
    model = '0;
    tick();
    chk(irq_line == 0, "R5", int'(irq_line), 0);

    // R10: withdraw while disabled
    glb_en = 1'b0;
    pulse_set(4'b0001);
    src_clr = 4'b0001;
    tick();
    src_clr = '0;
    chk(irq_line == 0, "R10", int'(irq_line), 0);
    // R7: set beats withdraw
    src_set = 4'b0001;
    src_clr = 4'b0001;
    tick();
    src_set = '0;
    src_clr = '0;
    chk(irq_line == 1, "R7", int'(irq_line), 1);

    // R6: enable and withdraw on the same edge -> spurious
    glb_en = 1'b1;
    src_clr = 4'b0001;
    tick();
    src_clr = '0;
    chk(ack == 1 && irq_line == 0, "R6", int'({ack, irq_line}), 2);
    take(d, s);
    chk(d == 0 && s == 1, "R6", int'({s, d}), 256);
    model = '0;

    // Random bursts
    for (int it = 0; it < 60; it++) begin
      logic [N-1:0] m;
      m = N'($urandom);
      if (m != 0) pulse_set(m);
      while (model != 0) begin
        int e;
        e = lowest(model);
        take(d, s);
        chk(d == vec_of(e) && !s, "R3", int'(d), int'(vec_of(e)));
        model[e] = 1'b0;
      end
      tick();
      chk(irq_line == 0 && !vec_valid, "R5", int'({irq_line, vec_valid}), 0);
    end

    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule